// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block drives the row and column strobes of an asynchronous DRAM array for initialisation and refresh. After reset it waits out a long power-up pause. It then runs eight wake-up refresh cycles and raises an init-done flag, which tells the access controller that normal traffic may begin. From then on a periodic interval timer marks when a row refresh is due. Due refreshes collect in a small saturating backlog.

Refresh uses column-before-row strobe ordering, so the DRAM supplies the row address from its own internal counter. The address bus, write enable and data pins are don't-cares during a refresh cycle. This block therefore has no address outputs and keeps no row counter. The sequencer shares the strobes with an access controller through a request/grant pair. It drives a refresh only when the controller grants the bus.

If the sequencer drives no row strobe for longer than the retention period, the array is treated as asleep. Init-done drops, and eight wake-up cycles must run again. All durations are parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: For PAUSE_CYC clock cycles after reset release, `ref_req_o` stays low and both strobes stay high. `ref_req_o` can first rise in the cycle after the PAUSE_CYC-th rising edge.
- R2: After the pause, WAKE_CYCLES (8) refresh cycles run before `init_done_o` rises. `init_done_o` rises in the cycle after the last of them releases the strobes.
- R3: From the end of the pause, a due tick occurs once every INTERVAL_CYC cycles. Each tick adds one to a backlog that saturates at BACKLOG_MAX (8). Each granted refresh that is not a wake-up cycle removes one entry from the backlog.
- R4: `ref_req_o` is high while no cycle is running and work is outstanding, and it stays high through a running refresh cycle. A cycle starts at a rising edge only if no cycle is running, work is outstanding and `ref_gnt_i` is high. While `ref_gnt_i` is low and no cycle is running, both strobes stay high.
- R5: A refresh cycle has three phases. For PRE_CYC cycles both strobes are high (row precharge). For CSR_CYC cycles `cas_n_o` is low and `ras_n_o` is high. For RAS_CYC cycles both are low. Both strobes then return high in the same cycle.
- R6: Once init-done is high, if the sequencer drives no row strobe low for STALE_CYC consecutive cycles, `init_done_o` drops. WAKE_CYCLES wake-up cycles are then required again, and these take priority over the backlog.
- R7: While reset is asserted, `ras_n_o` and `cas_n_o` are high, and `ref_req_o` and `init_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Access controller grants the strobes for a refresh |
| ref_req_o | output | 1 | Refresh work outstanding or refresh cycle running |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| init_done_o | output | 1 | Power-up sequence complete, normal access allowed |

## Verification
The bench targets the following corner cases:
- The exact cycle in which the pause ends. An off-by-one counter would raise the request one cycle early or late.
- The count of wake-up cycles before init-done. A design that miscounts would release the array too early.
- The backlog held at saturation while the grant is withheld. It then drains as exactly eight entries plus any ticks that arrive during the drain. A non-saturating or wrapping counter would issue too many or too few refreshes.
- A withheld grant that outlasts the retention window. Init-done must drop, and exactly eight wake-up cycles must pass before it returns. A design that served the backlog first, or skipped the re-wake, would fail.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_CSR  = 2'd2,
    ST_ACT  = 2'd3
  } ref_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned PERIOD = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == W'(PERIOD - 1));
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int unsigned MAX = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         inc_i,
  input  logic                         dec_i,
  output logic [$clog2(MAX+1)-1:0]     cnt_o,
  output logic                         busy_o
);
  localparam int unsigned W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != W'(MAX)) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);

  // R3: saturating backlog
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i && cnt_q == W'(MAX) |=> cnt_q == W'(MAX));
  a_r3_tick_adds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !dec_i && cnt_q < W'(MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter int unsigned PRE_CYC = 3,
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned RAS_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic end_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned MAXC = (PRE_CYC > CSR_CYC) ?
                                 ((PRE_CYC > RAS_CYC) ? PRE_CYC : RAS_CYC) :
                                 ((CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC);
  localparam int unsigned TW = $clog2(MAXC + 1);

  ref_state_e    state_q;
  logic [TW-1:0] tcnt_q;
  logic          phase_end;

  always_comb begin
    unique case (state_q)
      ST_PRE:  phase_end = (tcnt_q == TW'(PRE_CYC - 1));
      ST_CSR:  phase_end = (tcnt_q == TW'(CSR_CYC - 1));
      ST_ACT:  phase_end = (tcnt_q == TW'(RAS_CYC - 1));
      default: phase_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      tcnt_q <= '0;
      if (start_i) state_q <= ST_PRE;
    end else if (phase_end) begin
      tcnt_q <= '0;
      unique case (state_q)
        ST_PRE:  state_q <= ST_CSR;
        ST_CSR:  state_q <= ST_ACT;
        default: state_q <= ST_IDLE;
      endcase
    end else begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign end_o   = (state_q == ST_ACT) && phase_end;
  assign ras_n_o = (state_q != ST_ACT);
  assign cas_n_o = !((state_q == ST_CSR) || (state_q == ST_ACT));

  // R5: column strobe leads row strobe, both release together
  a_r5_cas_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  a_r5_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> $rose(cas_n_o));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned STALE_CYC    = 3200000,
  parameter int unsigned WAKE_CYCLES  = 8,
  parameter int unsigned BACKLOG_MAX  = 8,
  parameter int unsigned PRE_CYC      = 3,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned RAS_CYC      = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o
);
  localparam int unsigned WAKE_W  = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned STALE_W = (STALE_CYC > 1) ? $clog2(STALE_CYC) : 1;
  localparam int unsigned BL_W    = $clog2(BACKLOG_MAX + 1);

  logic               pause_done_q;
  logic               pause_tick, ivl_tick;
  logic [WAKE_W-1:0]  wake_q;
  logic [STALE_W-1:0] stale_q;
  logic [BL_W-1:0]    bl_cnt;
  logic               bl_busy, busy, cyc_end, start, work, waking, stale_hit;

  dram_ref_timer #(.PERIOD(PAUSE_CYC)) i_pause (
    .clk_i, .rst_ni, .en_i(!pause_done_q), .tick_o(pause_tick));

  dram_ref_timer #(.PERIOD(INTERVAL_CYC)) i_interval (
    .clk_i, .rst_ni, .en_i(pause_done_q), .tick_o(ivl_tick));

  assign waking = (wake_q != '0);
  assign work   = pause_done_q && (waking || bl_busy);
  assign start  = !busy && work && ref_gnt_i;

  dram_ref_backlog #(.MAX(BACKLOG_MAX)) i_backlog (
    .clk_i, .rst_ni, .inc_i(ivl_tick), .dec_i(start && !waking),
    .cnt_o(bl_cnt), .busy_o(bl_busy));

  dram_ref_strobe #(.PRE_CYC(PRE_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC)) i_strobe (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy), .end_o(cyc_end),
    .ras_n_o, .cas_n_o);

  assign init_done_o = pause_done_q && !waking;
  assign ref_req_o   = busy || work;
  assign stale_hit   = init_done_o && ras_n_o && (stale_q == STALE_W'(STALE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pause_done_q <= 1'b0;
    else if (pause_tick) pause_done_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wake_q <= WAKE_W'(WAKE_CYCLES);
    else if (stale_hit)          wake_q <= WAKE_W'(WAKE_CYCLES);
    else if (cyc_end && waking)  wake_q <= wake_q - 1'b1;
  end

  // counts cycles without a row strobe once initialised
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          stale_q <= '0;
    else if (!init_done_o || !ras_n_o)    stale_q <= '0;
    else if (stale_hit)                   stale_q <= '0;
    else                                  stale_q <= stale_q + 1'b1;
  end

  // R1: silent during power-up pause
  a_r1_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_done_q |-> ras_n_o && cas_n_o && !ref_req_o);
  // R2: init-done only rises right after a refresh cycle ends
  a_r2_done_after_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(!ras_n_o));
  // R4: strobes only move inside a granted cycle
  a_r4_strobe_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> ref_req_o);
  // R6: init-done drops only while the row strobe is idle
  a_r6_drop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_done_o) |-> ras_n_o && bl_cnt <= BL_W'(BACKLOG_MAX));
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int PAUSE = 40;
  localparam int IVL   = 70;
  localparam int STALE = 1000;
  localparam int WAKE  = 8;
  localparam int BLMAX = 8;
  localparam int PRE   = 2;
  localparam int CSR   = 1;
  localparam int RAS   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, ras_n, cas_n, done;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .STALE_CYC(STALE), .WAKE_CYCLES(WAKE),
    .BACKLOG_MAX(BLMAX), .PRE_CYC(PRE), .CSR_CYC(CSR), .RAS_CYC(RAS)
  ) i_dram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .ref_gnt_i(gnt), .ref_req_o(req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .init_done_o(done));

  int tests = 0, fails = 0;
  bit finished = 0;

  // behavioural model
  int m_cyc, m_pd, m_pcnt, m_icnt, m_wake, m_pend, m_phase, m_t, m_stale, m_ticks;

  function automatic bit m_req();
    bit work = (m_pd != 0) && (m_wake > 0 || m_pend > 0);
    return (m_phase != 0) || work;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_pd = 0; m_pcnt = 0; m_icnt = 0; m_wake = WAKE; m_pend = 0;
      m_phase = 0; m_t = 0; m_stale = 0; m_ticks = 0;
    end else begin
      bit work, take, fin, ptick, itick, dec, initd, hit;
      int lim;
      m_cyc++;
      work  = (m_pd != 0) && (m_wake > 0 || m_pend > 0);
      take  = (m_phase == 0) && work && gnt;
      fin   = (m_phase == 3) && (m_t == RAS - 1);
      ptick = (m_pd == 0) && (m_pcnt == PAUSE - 1);
      itick = (m_pd != 0) && (m_icnt == IVL - 1);
      dec   = take && (m_wake == 0);
      initd = (m_pd != 0) && (m_wake == 0);
      hit   = 0;
      if (m_pd == 0) m_pcnt = (m_pcnt == PAUSE - 1) ? 0 : m_pcnt + 1;
      else           m_icnt = (m_icnt == IVL - 1) ? 0 : m_icnt + 1;
      if (itick) m_ticks++;
      if (itick && !dec)      m_pend = (m_pend < BLMAX) ? m_pend + 1 : BLMAX;
      else if (dec && !itick) m_pend = m_pend - 1;
      if (!initd || m_phase == 3) m_stale = 0;
      else if (m_stale == STALE - 1) begin m_stale = 0; hit = 1; end
      else m_stale++;
      if (hit) m_wake = WAKE;
      else if (fin && m_wake > 0) m_wake--;
      if (m_phase == 0) begin
        m_t = 0;
        if (take) m_phase = 1;
      end else begin
        lim = (m_phase == 1) ? PRE : (m_phase == 2) ? CSR : RAS;
        if (m_t == lim - 1) begin m_t = 0; m_phase = (m_phase == 3) ? 0 : m_phase + 1; end
        else m_t++;
      end
      if (ptick) m_pd = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, m_cyc);
    end
  endtask

  // per-cycle comparison and row-strobe fall counter
  int falls = 0;
  logic ras_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 req", req, m_req());
      chk("R5 ras_n", ras_n, (m_phase != 3));
      chk("R5 cas_n", cas_n, !(m_phase >= 2));
      chk("R2 init_done", done, (m_pd != 0 && m_wake == 0));
      if (ras_prev && !ras_n) falls++;
      ras_prev = ras_n;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0, t0, n;
    cycles(3);
    // R7 reset state
    chk("R7 ras_n", ras_n, 1);
    chk("R7 cas_n", cas_n, 1);
    chk("R7 req", req, 0);
    chk("R7 init_done", done, 0);
    gnt = 1'b1;
    rst_n = 1'b1;
    // R1 pause boundary
    while (m_cyc < PAUSE - 1) @(negedge clk);
    chk("R1 req before pause end", req, 0);
    chk("R1 ras_n in pause", ras_n, 1);
    @(negedge clk);
    chk("R1 req at pause end", req, 1);
    // R2 eight wake cycles before init-done
    f0 = falls;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R2 init_done raised", done, 1);
    chk("R2 wake cycles", falls - f0, WAKE);
    cycles(300);
    // R4 withheld grant: no strobes
    gnt = 1'b0;
    cycles(10);
    f0 = falls;
    cycles(700);
    chk("R4 no refresh without grant", falls - f0, 0);
    chk("R4 req while pending", req, 1);
    chk("R3 backlog saturated", m_pend, BLMAX);
    chk("R6 still initialised", done, 1);
    // R3 drain: eight entries plus ticks during drain
    f0 = falls; t0 = m_ticks;
    gnt = 1'b1;
    @(negedge clk);
    n = 0;
    while (req && n < 2000) begin @(negedge clk); n++; end
    chk("R3 drain count", falls - f0, BLMAX + (m_ticks - t0));
    chk("R3 req idle", req, 0);
    // R6 stale window
    gnt = 1'b0;
    cycles(1100);
    chk("R6 init_done dropped", done, 0);
    f0 = falls;
    gnt = 1'b1;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R6 re-init done", done, 1);
    chk("R6 rewake cycles", falls - f0, WAKE);
    cycles(200);
    finish_run();
  end
endmodule